// File: doc/BRIEF.md
# Ternary Dot-Product MAC

This block computes dot products of ternary vectors for neural-network inference. Every beat it takes `LANES` weight trits and `LANES` activation trits. It multiplies each pair through a small lookup table and sums the products in a pipelined reduction tree. The tree result is then folded into a signed binary accumulator. The accumulator is wide enough to hold the largest permitted dot product without wrapping.

A dot product opens with a beat marked start, which carries the element count. It closes with a beat marked last. Elements beyond the count are masked to zero, so a vector whose length is not a multiple of the lane count needs no padding from the caller. The final sum appears on the output for one cycle at a fixed latency. On request, the sign of the sum is also given as a trit. A new dot product may start in the cycle right after the previous one ends.

Top module: `tdot_mac`

## Requirements
- R1: While reset is held and after it is released, with no input beats, `outValid` and `outTritValid` are 0 and `outAcc` is 0.
- R2: Trits are 2-bit codes per lane: 2'b01 is +1, 2'b11 is -1, 2'b00 is 0, and 2'b10 is read as 0. Lane i occupies bits [2i+1:2i] of `inWeight` and `inAct`, and its product is the signed product of the two values.
- R3: The result is the sum of all unmasked lane products over every beat of the dot product. Cycles with `inValid` low contribute nothing, whatever the other inputs carry.
- R4: A valid beat with `inStart` high begins a new dot product. Everything accumulated before it is discarded, including any dot product that was left unfinished.
- R5: `inLength` is sampled on the start beat and clamped to `MAX_LEN`. Lane i of the k-th beat (counting from 0 at the start beat) contributes only when k*LANES+i is less than the clamped length. Beats beyond the length contribute 0 until the last beat.
- R6: `outValid` is high for exactly one cycle, three cycles after the cycle that carries the valid last beat (tree depth 2 plus 1). `outAcc` holds the signed result during that cycle.
- R7: The signed value of `outAcc` never exceeds `MAX_LEN` in magnitude.
- R8: If `inTritReq` is high on the last beat, `outTritValid` rises together with `outValid`, and `outTrit` gives the sign of the result in the R2 code. Otherwise `outTritValid` stays 0 and `outTrit` reads 2'b00.
- R9: A start beat in the cycle directly after a last beat produces a correct second result, one cycle after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat qualifier |
| inStart | input | 1 | First beat of a dot product |
| inLast | input | 1 | Final beat of a dot product |
| inLength | input | LEN_W | Element count, sampled on the start beat |
| inTritReq | input | 1 | Request the sign-trit output, sampled on the last beat |
| inWeight | input | 2*LANES | Weight trits, one 2-bit code per lane |
| inAct | input | 2*LANES | Activation trits, one 2-bit code per lane |
| outValid | output | 1 | Result strobe |
| outAcc | output | ACC_W | Signed dot-product result |
| outTritValid | output | 1 | Sign-trit strobe |
| outTrit | output | 2 | Sign of the result as a trit code |

## Verification
Two events can fall in the same cycle: presenting one dot product's result, and reloading the accumulator for the next one. This happens when a start beat directly follows a last beat. The bench provokes it by sending two single-beat dot products back to back, with sums of opposite sign. It then checks that each result appears in its own consecutive cycle with the right value and sign trit. A second overlap is a fresh start that arrives before an open dot product is closed. The bench checks that the restarted sum carries nothing over from the abandoned one.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_POS  = 2'b01;
  localparam trit_t TRIT_NEG  = 2'b11;

  // Reduction tree registers between the lane inputs and the accumulator.
  localparam int PIPE_DEPTH = 2;

  // Strobes from control to datapath, aligned with the accumulator stage.
  typedef struct packed {
    logic accLoad;
    logic accAdd;
    logic emit;
    logic emitTrit;
  } macStrobe_t;

  // Product of two trit codes; the unused code 2'b10 behaves as zero.
  function automatic logic signed [1:0] tritMul(input trit_t a, input trit_t b);
    logic signed [1:0] r;
    unique case ({a, b})
      {TRIT_POS, TRIT_POS}, {TRIT_NEG, TRIT_NEG}: r = 2'sb01;
      {TRIT_POS, TRIT_NEG}, {TRIT_NEG, TRIT_POS}: r = 2'sb11;
      default:                                    r = 2'sb00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tdot_ctrl.sv
module tdot_ctrl
  import tdot_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             inLast,
  input  logic [LEN_W-1:0] inLength,
  input  logic             inTritReq,
  output logic [LANES-1:0] laneMask,
  output macStrobe_t       strobe
);

  localparam logic [LEN_W-1:0] MAX_LEN_C = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LANES_C   = LEN_W'(LANES);

  logic [LEN_W-1:0] remReg;
  logic [LEN_W-1:0] remNow;
  logic [LEN_W-1:0] lenClamped;

  always_comb begin
    lenClamped = (inLength > MAX_LEN_C) ? MAX_LEN_C : inLength;
    remNow     = inStart ? lenClamped : remReg;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign laneMask[i] = inValid && (remNow > LEN_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg <= '0;
    end else if (inValid) begin
      remReg <= (remNow > LANES_C) ? remNow - LANES_C : '0;
    end
  end

  // Beat attributes travel alongside the tree stages.
  logic [PIPE_DEPTH-1:0] vldP, stP, lstP, reqP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldP <= '0;
      stP  <= '0;
      lstP <= '0;
      reqP <= '0;
    end else begin
      vldP <= {vldP[PIPE_DEPTH-2:0], inValid};
      stP  <= {stP[PIPE_DEPTH-2:0],  inValid & inStart};
      lstP <= {lstP[PIPE_DEPTH-2:0], inValid & inLast};
      reqP <= {reqP[PIPE_DEPTH-2:0], inValid & inLast & inTritReq};
    end
  end

  always_comb begin
    strobe.accLoad  = vldP[PIPE_DEPTH-1] &  stP[PIPE_DEPTH-1];
    strobe.accAdd   = vldP[PIPE_DEPTH-1] & ~stP[PIPE_DEPTH-1];
    strobe.emit     = lstP[PIPE_DEPTH-1];
    strobe.emitTrit = reqP[PIPE_DEPTH-1];
  end

endmodule

// File: rtl/tdot_datapath.sv
module tdot_datapath
  import tdot_pkg::*;
#(
  parameter int LANES = 8,
  parameter int GROUP = 4,
  parameter int ACC_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*LANES-1:0] inWeight,
  input  logic [2*LANES-1:0] inAct,
  input  logic [LANES-1:0]   laneMask,
  input  macStrobe_t         strobe,
  output logic               outValid,
  output logic [ACC_W-1:0]   outAcc,
  output logic               outTritValid,
  output trit_t              outTrit
);

  localparam int NGROUPS = (LANES + GROUP - 1) / GROUP;
  localparam int NPAD    = NGROUPS * GROUP;
  localparam int GW      = $clog2(GROUP + 1) + 1;
  localparam int SW      = $clog2(LANES + 1) + 1;

  // Lane products, padded with zero lanes to fill the last group.
  logic signed [1:0] prodPad [NPAD];

  for (genvar p = 0; p < NPAD; p++) begin : g_lane
    if (p < LANES) begin : g_real
      assign prodPad[p] = laneMask[p] ? tritMul(inWeight[2*p +: 2], inAct[2*p +: 2]) : 2'sb00;
    end else begin : g_pad
      assign prodPad[p] = 2'sb00;
    end
  end

  // Tree stage 1: one compressor per group.
  logic signed [GW-1:0] grpSum [NGROUPS];
  logic signed [GW-1:0] grpReg [NGROUPS];

  always_comb begin
    for (int g = 0; g < NGROUPS; g++) begin
      grpSum[g] = '0;
      for (int k = 0; k < GROUP; k++) begin
        grpSum[g] = grpSum[g] + GW'(prodPad[g*GROUP + k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NGROUPS; g++) begin
      if (!rstN) grpReg[g] <= '0;
      else       grpReg[g] <= grpSum[g];
    end
  end

  // Tree stage 2: combine the group sums.
  logic signed [SW-1:0] totSum;
  logic signed [SW-1:0] totReg;

  always_comb begin
    totSum = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      totSum = totSum + SW'(grpReg[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) totReg <= '0;
    else       totReg <= totSum;
  end

  // Accumulator stage.
  logic signed [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc          <= '0;
      outValid     <= 1'b0;
      outTritValid <= 1'b0;
    end else begin
      if (strobe.accLoad)     acc <= ACC_W'(totReg);
      else if (strobe.accAdd) acc <= acc + ACC_W'(totReg);
      outValid     <= strobe.emit;
      outTritValid <= strobe.emitTrit;
    end
  end

  assign outAcc = acc;

  always_comb begin
    if (!outTritValid)      outTrit = TRIT_ZERO;
    else if (acc == '0)     outTrit = TRIT_ZERO;
    else if (acc < 0)       outTrit = TRIT_NEG;
    else                    outTrit = TRIT_POS;
  end

endmodule

// File: rtl/tdot_mac.sv
module tdot_mac
  import tdot_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int GROUP   = 4,
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ACC_W   = $clog2(MAX_LEN + 1) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inStart,
  input  logic               inLast,
  input  logic [LEN_W-1:0]   inLength,
  input  logic               inTritReq,
  input  logic [2*LANES-1:0] inWeight,
  input  logic [2*LANES-1:0] inAct,
  output logic               outValid,
  output logic [ACC_W-1:0]   outAcc,
  output logic               outTritValid,
  output logic [1:0]         outTrit
);

  logic [LANES-1:0] laneMask;
  macStrobe_t       strobe;

  tdot_ctrl #(
    .LANES  (LANES),
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inStart  (inStart),
    .inLast   (inLast),
    .inLength (inLength),
    .inTritReq(inTritReq),
    .laneMask (laneMask),
    .strobe   (strobe)
  );

  tdot_datapath #(
    .LANES(LANES),
    .GROUP(GROUP),
    .ACC_W(ACC_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .inWeight    (inWeight),
    .inAct       (inAct),
    .laneMask    (laneMask),
    .strobe      (strobe),
    .outValid    (outValid),
    .outAcc      (outAcc),
    .outTritValid(outTritValid),
    .outTrit     (outTrit)
  );

endmodule

// File: rtl/tdot_mac_checker.sv
module tdot_mac_checker #(
  parameter int MAX_LEN = 1024,
  parameter int ACC_W   = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inLast,
  input logic             outValid,
  input logic [ACC_W-1:0] outAcc,
  input logic             outTritValid,
  input logic [1:0]       outTrit
);

  int accVal;
  assign accVal = int'($signed(outAcc));

  // R6: a valid last beat yields the result strobe three cycles later
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |-> ##3 outValid);

  // R6: no result strobe without a last beat three cycles earlier
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inLast, 3));

  // R7: the accumulator stays within the configured bound
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accVal <= MAX_LEN) && (accVal >= -MAX_LEN));

  // R8: the trit strobe only accompanies a result strobe
  assert_trit_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    outTritValid |-> outValid);

  // R8: the trit output never shows the unused code
  assert_trit_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    outTrit != 2'b10);

endmodule

bind tdot_mac tdot_mac_checker #(.MAX_LEN(MAX_LEN), .ACC_W(ACC_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inLast      (inLast),
  .outValid    (outValid),
  .outAcc      (outAcc),
  .outTritValid(outTritValid),
  .outTrit     (outTrit)
);

// File: tb/tdot_mac_bench.sv
`timescale 1ns/1ps
module tdot_mac_bench;

  localparam int LANES = 8;
  localparam int LEN_W = 11;
  localparam int ACC_W = 12;
  localparam logic [15:0] ALL_POS = 16'h5555;
  localparam logic [15:0] ALL_NEG = 16'hFFFF;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0, inStart = 1'b0, inLast = 1'b0, inTritReq = 1'b0;
  logic [LEN_W-1:0]  inLength = '0;
  logic [2*LANES-1:0] inWeight = '0, inAct = '0;
  logic              outValid, outTritValid;
  logic [ACC_W-1:0]  outAcc;
  logic [1:0]        outTrit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tdot_mac u_tdot_mac (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inLast(inLast),
    .inLength(inLength), .inTritReq(inTritReq), .inWeight(inWeight), .inAct(inAct),
    .outValid(outValid), .outAcc(outAcc), .outTritValid(outTritValid), .outTrit(outTrit)
  );

  typedef struct packed {
    logic [15:0]       w;
    logic [15:0]       a;
    logic [10:0]       len;
    logic signed [15:0] exp;
  } vec_t;

  // Single-beat dot products: weights, activations, length, expected sum.
  localparam vec_t VECS [8] = '{
    '{16'h5555, 16'h5555, 11'd8,  16'sd8},   // R2 all +1 * +1
    '{16'h5555, 16'hFFFF, 11'd8, -16'sd8},   // R2 +1 * -1
    '{16'h5555, 16'h5555, 11'd3,  16'sd3},   // R5 partial beat
    '{16'h5555, 16'hDDDD, 11'd8,  16'sd0},   // R3 alternating cancels
    '{16'hFFFF, 16'hFFFF, 11'd0,  16'sd0},   // R5 zero length
    '{16'hAAAA, 16'h5555, 11'd8,  16'sd0},   // R2 unused code reads as 0
    '{16'hFFFF, 16'h5555, 11'd5, -16'sd5},   // R5 partial, negative
    '{16'h5555, 16'h5FFF, 11'd8, -16'sd4}    // R3 mixed signs
  };

  function automatic int signTrit(input int v);
    if (v > 0) return 1;
    if (v < 0) return 3;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic beat(input logic st, input logic lst, input logic req,
                      input logic [15:0] w, input logic [15:0] a, input logic [LEN_W-1:0] len);
    inValid = 1'b1; inStart = st; inLast = lst; inTritReq = req;
    inWeight = w; inAct = a; inLength = len;
    @(negedge clk);
  endtask

  // Cycle with inValid low but every other input busy (R3 ignore test).
  task automatic gap(input logic [15:0] w, input logic [15:0] a);
    inValid = 1'b0; inStart = 1'b1; inLast = 1'b1; inTritReq = 1'b1;
    inWeight = w; inAct = a; inLength = 11'd8;
    @(negedge clk);
  endtask

  task automatic idle();
    inValid = 1'b0; inStart = 1'b0; inLast = 1'b0; inTritReq = 1'b0;
    inWeight = '0; inAct = '0; inLength = '0;
    @(negedge clk);
  endtask

  // Called right after the last beat: result must appear exactly one idle later than the next.
  task automatic expectResult(input string tag, input int exp, input logic req);
    idle();
    chk({tag, " R6 no early strobe"}, int'(outValid), 0);
    idle();
    chk({tag, " R6 strobe"}, int'(outValid), 1);
    chk({tag, " R3 sum"}, int'($signed(outAcc)), exp);
    chk({tag, " R8 trit strobe"}, int'(outTritValid), int'(req));
    chk({tag, " R8 trit"}, int'(outTrit), req ? signTrit(exp) : 0);
    idle();
    chk({tag, " R6 single pulse"}, int'(outValid), 0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outValid", int'(outValid), 0);
    chk("R1 reset outAcc", int'(outAcc), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle outValid", int'(outValid), 0);
    chk("R1 idle outTritValid", int'(outTritValid), 0);
    chk("R1 idle outAcc", int'(outAcc), 0);

    // Table walk: single-beat dot products with start and last together.
    for (int v = 0; v < 8; v++) begin
      beat(1'b1, 1'b1, 1'b1, VECS[v].w, VECS[v].a, VECS[v].len);
      expectResult($sformatf("R2 vec%0d", v), int'(VECS[v].exp), 1'b1);
    end

    // R3/R5: three beats, length 20, idle gap with busy inputs, no trit request.
    beat(1'b1, 1'b0, 1'b0, ALL_POS, ALL_POS, 11'd20);
    gap(ALL_POS, ALL_POS);
    beat(1'b0, 1'b0, 1'b0, ALL_POS, ALL_POS, 11'd0);
    beat(1'b0, 1'b1, 1'b0, ALL_POS, ALL_POS, 11'd0);
    expectResult("R3 multi-beat gap", 20, 1'b0);

    // R5: beats past the length contribute nothing.
    beat(1'b1, 1'b0, 1'b1, ALL_POS, ALL_POS, 11'd8);
    beat(1'b0, 1'b0, 1'b1, ALL_POS, ALL_POS, 11'd0);
    beat(1'b0, 1'b1, 1'b1, ALL_POS, ALL_POS, 11'd0);
    expectResult("R5 excess beats", 8, 1'b1);

    // R4: a new start abandons the open dot product.
    beat(1'b1, 1'b0, 1'b1, ALL_POS, ALL_POS, 11'd8);
    beat(1'b1, 1'b1, 1'b1, ALL_POS, ALL_NEG, 11'd8);
    expectResult("R4 restart", -8, 1'b1);

    // R9: back-to-back single-beat dot products.
    beat(1'b1, 1'b1, 1'b1, ALL_POS, ALL_POS, 11'd8);
    beat(1'b1, 1'b1, 1'b1, ALL_POS, ALL_NEG, 11'd8);
    idle();
    chk("R9 first strobe", int'(outValid), 1);
    chk("R9 first sum", int'($signed(outAcc)), 8);
    chk("R9 first trit", int'(outTrit), 1);
    idle();
    chk("R9 second strobe", int'(outValid), 1);
    chk("R9 second sum", int'($signed(outAcc)), -8);
    chk("R9 second trit", int'(outTrit), 3);
    idle();
    chk("R9 strobe ends", int'(outValid), 0);

    // R5/R7: oversized length clamps to MAX_LEN (1024) over 130 beats.
    for (int k = 0; k < 130; k++) begin
      beat(k == 0, k == 129, 1'b1, ALL_POS, ALL_POS, 11'd2047);
    end
    expectResult("R7 clamp", 1024, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule